// File: doc/BRIEF.md
# NAND Sector Hamming Parity Generator

This block computes a single-error-correcting, double-error-detecting Hamming code over one sector of NAND page data while the bytes stream past. Every data bit has a position index equal to its byte address times eight plus its bit number. For each bit of that index the block keeps two running parities. The "odd" parity covers the data bits whose index has that bit set. The "even" parity covers the data bits whose index has that bit clear. With the default 512-byte sector the index is 12 bits wide, so the code word has 24 bits.

The block is used as follows. The host pulses `clr` before a sector, or drives it together with the sector's first byte, and then presents the sector bytes in address order with `in_valid`. Gaps between bytes are allowed. One cycle after the last byte is accepted, `done` pulses and `code` shows the packed, inverted code word. The word stays on `code` until the next sector completes. The inversion means that an erased sector (all 0xFF) gives an all-ones code, which matches erased spare bytes. Storing the code and correcting errors belong to other blocks.

Top module: `nand_sector_ecc`

## Requirements
- R1: After reset `done` is 0 and `code` is all ones (0xFFFFFF). The first byte accepted after reset counts as byte 0 of a sector, with no clear needed.
- R2: The bit at index i = 8*address + bit contributes to odd parity k when bit k of i is 1, and to even parity k when bit k of i is 0. `code[12+k]` is the inverted odd parity k and `code[k]` is the inverted even parity k, for k = 0..11.
- R3: A sector of all 0xFF bytes gives code 0xFFFFFF. A sector of all 0x00 bytes also gives code 0xFFFFFF.
- R4: A sector whose only 1 bit is at index i gives code {~i, i}: bits 23:12 hold the complement of i and bits 11:0 hold i.
- R5: `done` is high for exactly one cycle, in the cycle after byte SECTOR_BYTES-1 is accepted. The new `code` is visible in that same cycle.
- R6: `code` changes only in a cycle where `done` is high. It keeps its value across clears and across ignored bytes.
- R7: A `clr` without `in_valid` in the middle of a sector discards the partial result and does not raise `done`. The next SECTOR_BYTES bytes then form a fresh sector.
- R8: When `clr` and `in_valid` are high in the same cycle, the accumulation restarts and that byte is taken as byte 0 of the new sector, also in the middle of a sector.
- R9: After a sector completes, bytes arriving without a clear are ignored. They raise no `done`, leave `code` unchanged and do not affect the next sector.
- R10: Cycles with `in_valid` low neither advance the byte address nor change the parities, so any gap pattern gives the same code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Start-of-sector clear |
| in_valid | input | 1 | A data byte is present this cycle |
| in_data | input | 8 | Data byte, bit 0 is bit number 0 |
| code | output | 24 | Packed, inverted code word of the last completed sector |
| done | output | 1 | One-cycle pulse when `code` is updated |

## Verification
A clear and a byte can arrive in the same cycle. This case is provoked both at a sector start and after a partial sector of unrelated bytes. It is judged correct when the following 512 bytes produce exactly the code the bench computes for them, with no `done` raised for the abandoned part. A byte can also arrive in the cycle after the sector has filled. The bench sends a long burst of such bytes and expects no `done`, an unchanged `code` and a correct result for the next sector.

// File: rtl/nsecc_pkg.sv
package nsecc_pkg;

  // default geometry of one protected sector
  localparam int unsigned NSE_SECTOR_BYTES = 512;
  localparam int unsigned NSE_BYTE_BITS    = 8;

  // whether the current sector still takes bytes
  typedef enum logic {
    SEC_FILL = 1'b0,
    SEC_FULL = 1'b1
  } sec_state_e;

endpackage

// File: rtl/nse_sector_track.sv
module nse_sector_track
  import nsecc_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES = NSE_SECTOR_BYTES,
  parameter int unsigned ADDR_W       = $clog2(SECTOR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  output logic              accept,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              last,
  output logic              full
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(SECTOR_BYTES - 1);

  logic [ADDR_W-1:0] addr_q;
  sec_state_e        st_q;

  // a clear in the same cycle turns the byte into byte 0
  assign accept   = in_valid && (clr || st_q == SEC_FILL);
  assign eff_addr = clr ? '0 : addr_q;
  assign last     = accept && (eff_addr == LAST_ADDR);
  assign full     = (st_q == SEC_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      st_q   <= SEC_FILL;
    end else if (accept) begin
      if (last) begin
        addr_q <= '0;
        st_q   <= SEC_FULL;
      end else begin
        addr_q <= eff_addr + 1'b1;
        st_q   <= SEC_FILL;
      end
    end else if (clr) begin
      addr_q <= '0;
      st_q   <= SEC_FILL;
    end
  end

  // R10: idle cycles leave the position untouched
  a_r10_gap_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> ($stable(addr_q) && $stable(st_q)));

  // R7: a lone clear rewinds to byte 0 of an open sector
  a_r7_clear_rewind : assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !in_valid) |=> (addr_q == '0 && st_q == SEC_FILL));

  // R8: clear with a byte leaves the sector positioned at byte 1
  a_r8_clear_take : assert property (@(posedge clk) disable iff (!rst_n)
    (clr && in_valid && SECTOR_BYTES > 1) |=> (addr_q == ADDR_W'(1)));

endmodule

// File: rtl/nse_parity_accum.sv
module nse_parity_accum
  import nsecc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 9,
  parameter int unsigned BYTE_BITS = NSE_BYTE_BITS,
  parameter int unsigned BIT_W     = $clog2(BYTE_BITS),
  parameter int unsigned IDX_W     = ADDR_W + BIT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 accept,
  input  logic [ADDR_W-1:0]    eff_addr,
  input  logic [BYTE_BITS-1:0] data,
  output logic [IDX_W-1:0]     sum_odd,
  output logic [IDX_W-1:0]     sum_even
);

  // bits of a byte whose bit number has bit k set
  function automatic logic [BYTE_BITS-1:0] col_mask(input int k);
    logic [BYTE_BITS-1:0] m;
    for (int j = 0; j < BYTE_BITS; j++) m[j] = j[k];
    return m;
  endfunction

  logic [IDX_W-1:0] acc_odd, acc_even;
  logic [IDX_W-1:0] odd_t, even_t;
  logic [IDX_W-1:0] base_odd, base_even;
  logic             row_par;

  assign row_par = ^data;

  // per index bit: a column term inside the byte, or a line term on the address
  for (genvar k = 0; k < IDX_W; k++) begin : g_term
    if (k < BIT_W) begin : g_col
      localparam logic [BYTE_BITS-1:0] MASK = col_mask(k);
      assign odd_t[k]  = ^(data & MASK);
      assign even_t[k] = ^(data & ~MASK);
    end else begin : g_line
      assign odd_t[k]  = row_par & eff_addr[k-BIT_W];
      assign even_t[k] = row_par & ~eff_addr[k-BIT_W];
    end
  end

  assign base_odd  = clr ? '0 : acc_odd;
  assign base_even = clr ? '0 : acc_even;
  assign sum_odd   = base_odd ^ odd_t;
  assign sum_even  = base_even ^ even_t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_odd  <= '0;
      acc_even <= '0;
    end else if (accept) begin
      acc_odd  <= sum_odd;
      acc_even <= sum_even;
    end else if (clr) begin
      acc_odd  <= '0;
      acc_even <= '0;
    end
  end

  // R9: a byte that is not accepted leaves the parities alone
  a_r9_ignored_bytes : assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !clr) |=> ($stable(acc_odd) && $stable(acc_even)));

  // R7: a lone clear wipes the partial parities
  a_r7_partial_drop : assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !accept) |=> (acc_odd == '0 && acc_even == '0));

  // R2: each data bit lands in exactly one of the two parities per index bit
  a_r2_pair_split : assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ((odd_t ^ even_t) == {IDX_W{row_par}}));

endmodule

// File: rtl/nse_code_pack.sv
module nse_code_pack #(
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned CODE_W = 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last,
  input  logic [IDX_W-1:0]  sum_odd,
  input  logic [IDX_W-1:0]  sum_even,
  output logic [CODE_W-1:0] code,
  output logic              done
);

  // odd field on top, even field below, whole word inverted
  function automatic logic [CODE_W-1:0] pack_word(input logic [IDX_W-1:0] o,
                                                  input logic [IDX_W-1:0] e);
    return ~{o, e};
  endfunction

  logic [CODE_W-1:0] code_q;
  logic              done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '1;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (last) code_q <= pack_word(sum_odd, sum_even);
    end
  end

  assign code = code_q;
  assign done = done_q;

  // R6: the code word only moves with the done strobe
  a_r6_code_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(code_q));

  // R5: done never lasts two cycles
  a_r5_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/nand_sector_ecc.sv
module nand_sector_ecc
  import nsecc_pkg::*;
#(
  parameter int unsigned SECTOR_BYTES = NSE_SECTOR_BYTES,
  parameter int unsigned BYTE_BITS    = NSE_BYTE_BITS,
  localparam int unsigned ADDR_W      = $clog2(SECTOR_BYTES),
  localparam int unsigned BIT_W       = $clog2(BYTE_BITS),
  localparam int unsigned IDX_W       = ADDR_W + BIT_W,
  localparam int unsigned CODE_W      = 2 * IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 in_valid,
  input  logic [BYTE_BITS-1:0] in_data,
  output logic [CODE_W-1:0]    code,
  output logic                 done
);

  logic              accept;
  logic              last;
  logic              full;
  logic [ADDR_W-1:0] eff_addr;
  logic [IDX_W-1:0]  sum_odd, sum_even;

  nse_sector_track #(
    .SECTOR_BYTES(SECTOR_BYTES),
    .ADDR_W      (ADDR_W)
  ) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .in_valid(in_valid),
    .accept  (accept),
    .eff_addr(eff_addr),
    .last    (last),
    .full    (full)
  );

  nse_parity_accum #(
    .ADDR_W   (ADDR_W),
    .BYTE_BITS(BYTE_BITS),
    .BIT_W    (BIT_W),
    .IDX_W    (IDX_W)
  ) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .accept  (accept),
    .eff_addr(eff_addr),
    .data    (in_data),
    .sum_odd (sum_odd),
    .sum_even(sum_even)
  );

  nse_code_pack #(
    .IDX_W (IDX_W),
    .CODE_W(CODE_W)
  ) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .last    (last),
    .sum_odd (sum_odd),
    .sum_even(sum_even),
    .code    (code),
    .done    (done)
  );

  // R5: a done strobe always follows a cycle that carried a byte
  a_r5_done_after_byte : assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid));

  // R9: a filled sector raises no done until it is cleared
  a_r9_full_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> !done);

endmodule

// File: tb/sim_nand_sector_ecc.sv
module sim_nand_sector_ecc;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic [23:0] code;
  logic        done;

  int checks = 0;
  int errors = 0;
  logic [7:0]  mem [512];
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  nand_sector_ecc u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_data(in_data), .code(code), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // parity by index bit, walked over every bit of the sector
  function automatic logic [23:0] exp_code();
    logic [11:0] po = '0;
    logic [11:0] pe = '0;
    for (int i = 0; i < 4096; i++) begin
      if (mem[i / 8][i % 8]) begin
        for (int k = 0; k < 12; k++) begin
          if (((i >> k) & 1) == 1) po[k] = ~po[k];
          else                     pe[k] = ~pe[k];
        end
      end
    end
    return ~{po, pe};
  endfunction

  function automatic logic [7:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[7:0];
  endfunction

  task automatic fill_const(input logic [7:0] v);
    for (int i = 0; i < 512; i++) mem[i] = v;
  endtask

  task automatic fill_rand();
    for (int i = 0; i < 512; i++) mem[i] = next_rand();
  endtask

  task automatic fill_single(input int idx);
    fill_const(8'h00);
    mem[idx / 8][idx % 8] = 1'b1;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    clr = 1'b1;
    in_valid = 1'b0;
  endtask

  // feeds unrelated bytes, never expecting a done
  task automatic feed_junk(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (done) bad++;
      clr = 1'b0;
      in_valid = 1'b1;
      in_data = next_rand();
    end
    @(negedge clk);
    if (done) bad++;
    in_valid = 1'b0;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic run_sector(input bit clr_first, input int gap, input string req);
    logic [23:0] exp = exp_code();
    int bad = 0;
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      if (done) bad++;
      clr = clr_first && (i == 0);
      in_valid = 1'b1;
      in_data = mem[i];
      if (i < 511) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          if (done) bad++;
          clr = 1'b0;
          in_valid = 1'b0;
          in_data = next_rand();
        end
      end
    end
    @(negedge clk);
    clr = 1'b0;
    in_valid = 1'b0;
    chk(done == 1'b1, "R5 done after last byte", done, 1);
    chk(code == exp, req, code, exp);
    @(negedge clk);
    chk(done == 1'b0, "R5 done single cycle", done, 0);
    chk(bad == 0, "R5 no early done", bad, 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog act=%h exp=%h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] held;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(code == 24'hFFFFFF, "R1 reset code", code, 24'hFFFFFF);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 first sector needs no clear; R3 erased sector
    fill_const(8'hFF);
    run_sector(1'b0, 0, "R3 erased sector");

    fill_const(8'h00);
    pulse_clr();
    run_sector(1'b0, 0, "R3 zero sector");

    // R4 single set bit, one per index bit plus both ends
    for (int k = -1; k < 13; k++) begin
      int idx = (k < 0) ? 0 : ((k == 12) ? 4095 : (1 << k));
      fill_single(idx);
      if (k % 2 == 0) begin
        run_sector(1'b1, 0, "R8 clear with first byte");
      end else begin
        pulse_clr();
        run_sector(1'b0, 0, "R2 single bit");
      end
      chk(code == {~idx[11:0], idx[11:0]}, "R4 single bit closed form",
          code, {~idx[11:0], idx[11:0]});
    end

    // R2 random data, R10 with gaps of 0, 1, 2 idle cycles
    for (int g = 0; g < 3; g++) begin
      fill_rand();
      run_sector(1'b1, g, "R10 gapped random sector");
    end

    // R7 lone clear mid-sector discards the partial data
    fill_rand();
    pulse_clr();
    feed_junk(200, "R7 no done on partial");
    held = code;
    pulse_clr();
    @(negedge clk);
    clr = 1'b0;
    chk(code == held, "R6 code kept across clear", code, held);
    chk(done == 1'b0, "R7 no done on clear", done, 0);
    run_sector(1'b0, 0, "R7 sector after mid clear");

    // R8 clear with a byte in the middle of a sector
    fill_rand();
    pulse_clr();
    feed_junk(100, "R8 no done on partial");
    run_sector(1'b1, 0, "R8 restart mid-sector");

    // R9 bytes after a full sector are ignored
    held = code;
    feed_junk(600, "R9 no done when full");
    chk(code == held, "R9 code unchanged by ignored bytes", code, held);
    fill_rand();
    run_sector(1'b1, 1, "R9 next sector unaffected");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule